// File: doc/BRIEF.md
# Checkpointing Retire Decision Controller

This block looks at the oldest entry of a small reorder buffer every cycle and chooses its fate: normal commit, virtual commit, opening a checkpoint followed by virtual retirement, or waiting. Virtual retirement frees the reorder-buffer slot while the instruction stays in its issue queue and load/store queue. This lets a small reorder buffer tolerate long-latency operations. A misprediction or exception later rolls the machine back to the checkpoint.

The head status arrives as single-bit flags: valid, completed, operands ready, long-latency class, store, store address known and store data known. The checkpoint table reports whether it is full or empty. The decision is registered. Flags sampled at one rising edge produce exactly one action strobe, plus its side-band signals, after that edge. The side-band signals are: release of the reorder-buffer slot, retention of the load/store queue entry, a request to block a store's data register, and a one-cycle fence that tells the store buffer to hold younger stores behind the new checkpoint.

Top module: `ckr_retire_ctl`

## Requirements
- R1: A valid non-store head with completed=1 gives the commit strobe with the slot release set and the queue-retain flag clear.
- R2: A valid non-store head that is not completed, has operands ready=0, and sees a non-empty checkpoint table gives the virtual-commit strobe with both the slot release and the queue-retain flag set.
- R3: A valid non-store head with completed=0, operands ready=1 and long-latency=1, when the table is not full, gives the checkpoint-create strobe with both the slot release and the queue-retain flag set.
- R4: A valid non-store head with completed=0, operands ready=1 and long-latency=0 gives the stall strobe with nothing released.
- R5: A store is never retired virtually and never opens a checkpoint. With its address unknown it stalls, whatever its other flags are. With its address known it commits.
- R6: The data-block request is raised only together with the commit of a store whose address is known and whose data is not known.
- R7: The store-buffer fence is high for exactly the cycles in which the checkpoint-create strobe is high.
- R8: A head that would be committed virtually while the checkpoint table is empty opens a checkpoint instead.
- R9: When the table is full, a head that would open a new checkpoint gives the stall strobe instead.
- R10: For a valid head exactly one of the four strobes is high in the cycle after sampling. For an invalid head, and while reset is high, every output is low.
- R11: Priority of the decision, highest first: store rules, then completed, then operands-not-ready, then the long/short split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | 1 | Reorder buffer head holds an instruction |
| head_done | input | 1 | Head has completed execution |
| head_ops_ready | input | 1 | Head source operands are available |
| head_long_lat | input | 1 | Head belongs to the long-latency class |
| head_is_store | input | 1 | Head is a store |
| head_addr_known | input | 1 | Store address has been computed |
| head_data_known | input | 1 | Store data value is available |
| ckpt_full | input | 1 | Checkpoint table has no free entry |
| ckpt_empty | input | 1 | Checkpoint table has no open entry |
| do_commit | output | 1 | Normal commit strobe |
| do_virt_commit | output | 1 | Virtual commit into the youngest open checkpoint |
| do_ckpt_create | output | 1 | Open a checkpoint and retire the head virtually |
| do_stall | output | 1 | Head stays; retirement waits |
| rob_release | output | 1 | Free the reorder-buffer slot |
| lsq_retain | output | 1 | Keep the load/store queue entry, marked virtually retired |
| store_data_block | output | 1 | Block the retiring store's data register |
| sb_fence | output | 1 | Store buffer holds younger stores behind the new checkpoint |

## Verification
The assertions assume that the table never reports full and empty at the same time. They also assume that the flags are stable between clock edges. The stimulus keeps to both: every vector drives a consistent full/empty pair and changes inputs only just after a rising edge. Every flag is treated as meaningful regardless of the instruction class, so the vectors also set store-only flags on non-stores, and completion or readiness on stores, to show which inputs each rule ignores.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_COMMIT = 3'd1,
        ACT_VIRT   = 3'd2,
        ACT_CKPT   = 3'd3,
        ACT_STALL  = 3'd4
    } ret_act_e;

    typedef struct packed {
        logic valid;
        logic done;
        logic ops_ready;
        logic long_lat;
        logic is_store;
        logic addr_known;
        logic data_known;
    } head_stat_t;

    typedef struct packed {
        logic full;
        logic empty;
    } ckpt_stat_t;

    typedef struct packed {
        ret_act_e act;
        logic     data_block;
    } ret_dec_t;

    // Store rules first, then completion, then readiness, then class.
    function automatic ret_dec_t decide(input head_stat_t h, input ckpt_stat_t c);
        ret_dec_t d;
        logic     need_new;
        d.act        = ACT_NONE;
        d.data_block = 1'b0;
        need_new     = 1'b0;
        if (h.valid) begin
            if (h.is_store) begin
                if (h.addr_known) begin
                    d.act        = ACT_COMMIT;
                    d.data_block = ~h.data_known;
                end else begin
                    d.act = ACT_STALL;
                end
            end else if (h.done) begin
                d.act = ACT_COMMIT;
            end else if (!h.ops_ready) begin
                if (c.empty) need_new = 1'b1;
                else         d.act    = ACT_VIRT;
            end else if (h.long_lat) begin
                need_new = 1'b1;
            end else begin
                d.act = ACT_STALL;
            end
            if (need_new) d.act = c.full ? ACT_STALL : ACT_CKPT;
        end
        return d;
    endfunction

endpackage

// File: rtl/ckr_decide.sv
module ckr_decide
    import ckr_pkg::*;
(
    input  head_stat_t head,
    input  ckpt_stat_t ckpt,
    output ret_dec_t   dec
);
    always_comb begin
        dec = decide(head, ckpt);
    end
endmodule

// File: rtl/ckr_strobe_reg.sv
module ckr_strobe_reg
    import ckr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ret_dec_t dec,
    output logic     s_commit,
    output logic     s_virt,
    output logic     s_ckpt,
    output logic     s_stall,
    output logic     s_release,
    output logic     s_retain,
    output logic     s_block,
    output logic     s_fence
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s_commit  <= 1'b0;
            s_virt    <= 1'b0;
            s_ckpt    <= 1'b0;
            s_stall   <= 1'b0;
            s_release <= 1'b0;
            s_retain  <= 1'b0;
            s_block   <= 1'b0;
            s_fence   <= 1'b0;
        end else begin
            s_commit  <= (dec.act == ACT_COMMIT);
            s_virt    <= (dec.act == ACT_VIRT);
            s_ckpt    <= (dec.act == ACT_CKPT);
            s_stall   <= (dec.act == ACT_STALL);
            s_release <= (dec.act == ACT_COMMIT) || (dec.act == ACT_VIRT) || (dec.act == ACT_CKPT);
            s_retain  <= (dec.act == ACT_VIRT) || (dec.act == ACT_CKPT);
            s_block   <= dec.data_block;
            s_fence   <= (dec.act == ACT_CKPT);
        end
    end
endmodule

// File: rtl/ckr_retire_ctl.sv
module ckr_retire_ctl
    import ckr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic head_valid,
    input  logic head_done,
    input  logic head_ops_ready,
    input  logic head_long_lat,
    input  logic head_is_store,
    input  logic head_addr_known,
    input  logic head_data_known,
    input  logic ckpt_full,
    input  logic ckpt_empty,
    output logic do_commit,
    output logic do_virt_commit,
    output logic do_ckpt_create,
    output logic do_stall,
    output logic rob_release,
    output logic lsq_retain,
    output logic store_data_block,
    output logic sb_fence
);
    head_stat_t head;
    ckpt_stat_t ckpt;
    ret_dec_t   dec;

    always_comb begin
        head.valid      = head_valid;
        head.done       = head_done;
        head.ops_ready  = head_ops_ready;
        head.long_lat   = head_long_lat;
        head.is_store   = head_is_store;
        head.addr_known = head_addr_known;
        head.data_known = head_data_known;
        ckpt.full       = ckpt_full;
        ckpt.empty      = ckpt_empty;
    end

    ckr_decide u_decide (
        .head (head),
        .ckpt (ckpt),
        .dec  (dec)
    );

    ckr_strobe_reg u_sreg (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .s_commit  (do_commit),
        .s_virt    (do_virt_commit),
        .s_ckpt    (do_ckpt_create),
        .s_stall   (do_stall),
        .s_release (rob_release),
        .s_retain  (lsq_retain),
        .s_block   (store_data_block),
        .s_fence   (sb_fence)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({do_commit, do_virt_commit, do_ckpt_create, do_stall})); // R10
    AST_VALID_ACTS: assert property (@(posedge clk) disable iff (rst)
        head_valid |=> $countones({do_commit, do_virt_commit, do_ckpt_create, do_stall}) == 1); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !head_valid |=> !rob_release && !do_stall && !sb_fence); // R10
    AST_STORE_NO_VIRT: assert property (@(posedge clk) disable iff (rst)
        (head_valid && head_is_store) |=> !do_virt_commit && !do_ckpt_create); // R5
    AST_FULL_NO_CKPT: assert property (@(posedge clk) disable iff (rst)
        ckpt_full |=> !do_ckpt_create); // R9
    AST_SHORT_STALL: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !head_is_store && !head_done && head_ops_ready && !head_long_lat) |=> do_stall); // R4
    AST_BLOCK_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        store_data_block |-> do_commit); // R6
    AST_FENCE_CKPT: assert property (@(posedge clk) disable iff (rst)
        sb_fence |-> do_ckpt_create); // R7
    AST_RETAIN_FREES: assert property (@(posedge clk) disable iff (rst)
        lsq_retain |-> rob_release && !do_commit); // R3

endmodule

// File: tb/ckr_retire_ctl_tb_top.sv
module ckr_retire_ctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v, d, r, l, s, a, k, f, e;
    logic o_c, o_v, o_k, o_s, o_rf, o_lk, o_bk, o_fn;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ckr_retire_ctl dut_i (
        .clk(clk), .rst(rst),
        .head_valid(v), .head_done(d), .head_ops_ready(r), .head_long_lat(l),
        .head_is_store(s), .head_addr_known(a), .head_data_known(k),
        .ckpt_full(f), .ckpt_empty(e),
        .do_commit(o_c), .do_virt_commit(o_v), .do_ckpt_create(o_k), .do_stall(o_s),
        .rob_release(o_rf), .lsq_retain(o_lk), .store_data_block(o_bk), .sb_fence(o_fn)
    );

    // stim {v,d,r,l,s,a,k,f,e}, expect {commit,virt,ckpt,stall,release,retain,block,fence}
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        {9'b0_000_000_00, 8'b0000_0000},  // R10 idle
        {9'b1_100_000_00, 8'b1000_1000},  // R1 completed
        {9'b1_101_000_10, 8'b1000_1000},  // R1 completed long, table full
        {9'b1_000_000_00, 8'b0100_1100},  // R2 not ready, open checkpoint
        {9'b1_000_000_01, 8'b0010_1101},  // R8 not ready, table empty
        {9'b1_000_000_10, 8'b0100_1100},  // R2 full table still allows virtual commit
        {9'b1_011_000_00, 8'b0010_1101},  // R3 long ready incomplete
        {9'b1_011_000_10, 8'b0001_0000},  // R9 long but table full
        {9'b1_010_000_00, 8'b0001_0000},  // R4 short ready incomplete
        {9'b1_010_011_00, 8'b0001_0000},  // R4 store flags ignored on non-store
        {9'b1_000_100_01, 8'b0001_0000},  // R5 store address unknown
        {9'b1_110_100_00, 8'b0001_0000},  // R5 store done but address unknown
        {9'b1_000_111_00, 8'b1000_1000},  // R5 store address and data known
        {9'b1_000_110_01, 8'b1000_1010},  // R6 store data unknown
        {9'b1_001_000_00, 8'b0100_1100},  // R11 not ready wins over long class
        {9'b1_000_000_00, 8'b0100_1100}   // R2 repeated
    };
    localparam int TAG [NV] = '{10, 1, 1, 2, 8, 2, 3, 9, 4, 4, 5, 5, 5, 6, 11, 2};

    task automatic drive(input logic [8:0] st);
        {v, d, r, l, s, a, k, f, e} = st;
    endtask

    task automatic check(input int tag, input logic [7:0] exp);
        logic [7:0] got;
        got = {o_c, o_v, o_k, o_s, o_rf, o_lk, o_bk, o_fn};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d got=%b expected=%b", tag, got, exp);
        end
    endtask

    initial begin
        drive(9'b1_011_000_00);
        repeat (3) @(posedge clk);
        #1 check(10, 8'b0000_0000);  // R10 outputs low during reset
        rst = 1'b0;
        drive(9'b0);
        @(posedge clk); #1;
        check(10, 8'b0000_0000);     // R10 reset state / idle
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:8]);
            @(posedge clk); #1;
            check(TAG[i], VEC[i][7:0]);
        end
        // R7 fence lasts one cycle only: checkpoint then plain commit
        drive(9'b1_011_000_00);
        @(posedge clk); #1;
        check(7, 8'b0010_1101);
        drive(9'b1_100_000_00);
        @(posedge clk); #1;
        check(7, 8'b1000_1000);
        // R10 reset mid-stream clears strobes
        drive(9'b1_000_000_01);
        rst = 1'b1;
        @(posedge clk); #1;
        check(10, 8'b0000_0000);
        rst = 1'b0;
        @(posedge clk); #1;
        check(8, 8'b0010_1101);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule